// File: doc/BRIEF.md
# PCM TDM Slot Timing Engine

This block keeps frame and slot time on a shared time-division-multiplexed PCM voice bus. It runs directly on the bit clock. Each frame is divided into 16-bit slots, and the number of slots follows from the selected audio sample rate and interface bit rate. As bus master the block generates the frame sync itself. As slave it locks onto a sync pulse arriving on the pin. Both short (one bit) and long (three bit) sync pulses are supported in either role.

Up to three full-duplex voice channels are each given a slot number. Transmit and receive of a channel share that slot. For every bit of the frame the block presents the bit and slot position, slot start and end strobes, and one slot-active line per channel. The per-channel serializers use these to launch data on rising edges and capture it on falling edges. The block also drives the enable of the shared data output. That enable is high only inside owned slots and drops at the falling edge within the last bit of each owned slot, which frees the line for other talkers.

Top module: `pcm_tdm_timing`

## Requirements
- R1: The interface rate select codes 0, 1, 2, 3 and 4 mean 128, 256, 512, 1024 and 2048 kbps. At 8 kHz (`rate_16k` low) these codes give 1, 2, 4, 8 and 16 slots per frame. At 16 kHz, codes 1 to 4 give 1, 2, 4 and 8 slots.
- R2: `bit_idx` counts 0..15 within a slot and `slot_idx` counts the slots. Both advance on every rising bit-clock edge and return to bit 0 of slot 0 after the last bit of the last slot.
- R3: As master with short sync, `sync_out` is high for exactly the last bit period of each frame, and `sync_oe` is high.
- R4: As master with long sync, `sync_out` is high for the first three bit periods of slot 0.
- R5: `slot_active[c]` is high for the whole of slot `ch_slot[4c+3:4c]` when `ch_en[c]` is set and timing is valid. The same indication serves both transmit and receive of that channel.
- R6: `dout_oe` is low during every slot that no enabled channel owns, and high from the first rising edge of an owned slot.
- R7: In the last bit of an owned slot, `dout_oe` goes low at that bit's falling edge.
- R8: As slave with short sync, a sync first seen high at a falling edge makes the next rising edge start bit 0 of slot 0.
- R9: As slave with long sync, a sync first seen high at a falling edge marks bit 0 of slot 0, so the next rising edge starts bit 1.
- R10: As slave before the first sync, `locked` is low, no `slot_active` is high, `dout_oe` is low, and `sync_oe` is low.
- R11: The first sync in slave mode aligns the counters without raising `resync_seen`. Once locked, a sync at any other position realigns the counters and sets `resync_seen`, which stays set until reset.
- R12: As master, `sync_in` has no effect on the counters or on `resync_seen`.
- R13: While reset is asserted, `bit_idx` and `slot_idx` are 0 and `locked` and `resync_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus bit clock; rising edge launches, falling edge samples |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | 1 = generate frame sync, 0 = follow `sync_in` |
| long_sync | input | 1 | 0 = one-bit sync pulse, 1 = three-bit sync pulse |
| rate_16k | input | 1 | Sample rate: 0 = 8 kHz, 1 = 16 kHz |
| if_rate_sel | input | 3 | Interface bit-rate code (see R1) |
| ch_en | input | N_CH | Per-channel enable |
| ch_slot | input | N_CH*MAX_SLOT_LOG2 | Slot number of each channel, channel c at bits [4c+3:4c] |
| sync_in | input | 1 | Frame sync pin as seen by the block |
| sync_out | output | 1 | Generated frame sync (master) |
| sync_oe | output | 1 | Drive enable for the sync pin |
| bit_idx | output | 4 | Bit position within the current slot |
| slot_idx | output | MAX_SLOT_LOG2 | Current slot number |
| slot_first | output | 1 | High during bit 0 of any slot |
| slot_last | output | 1 | High during the last bit of any slot |
| slot_active | output | N_CH | Per-channel shift strobe: channel owns the current slot |
| dout_oe | output | 1 | Enable of the shared data output driver |
| locked | output | 1 | Slave has aligned to a sync (low in master) |
| resync_seen | output | 1 | Sticky flag: a locked slave saw a misplaced sync |

## Verification
The assertions assume three things about the inputs. Mode, rate and slot assignments change only while reset is held. The enabled channels carry distinct slot numbers. The rate select is one of the listed combinations. The stimulus keeps within these limits: it draws every configuration with the seeded generator under reset, and it picks distinct slots by rejection, disabling any channel that cannot get a free slot. Slave sync pulses are 1 or 3 bit periods wide with a low gap before each rising edge, and each misplaced pulse is started at a chosen position inside a locked frame.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;

   localparam int unsigned RATE_SEL_W = 3;

   typedef enum logic {
      SYNC_SHORT = 1'b0,
      SYNC_LONG  = 1'b1
   } sync_kind_e;

   // log2 of slots per frame for a sample-rate / interface-rate pair
   function automatic int unsigned frame_slot_log2(input logic wide16,
                                                   input logic [RATE_SEL_W-1:0] sel,
                                                   input int unsigned max_log2);
      int unsigned s;
      s = int'(sel);
      if (wide16) s = (s == 0) ? 0 : s - 1;
      if (s > max_log2) s = max_log2;
      return s;
   endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter
   import pcm_tdm_pkg::*;
#(
   parameter  int unsigned SLOT_BITS     = 16,
   parameter  int unsigned MAX_SLOT_LOG2 = 4,
   localparam int unsigned POS_W         = $clog2(SLOT_BITS) + MAX_SLOT_LOG2
) (
   input  logic                  bclk,
   input  logic                  rst_n,
   input  logic                  master_en,
   input  logic                  long_sync,
   input  logic                  rate_16k,
   input  logic [RATE_SEL_W-1:0] if_rate_sel,
   input  logic                  sync_in,
   output logic [POS_W-1:0]      pos,
   output logic [POS_W-1:0]      last_pos,
   output logic                  lock_q,
   output logic                  resync_q
);

   logic             sync_q, sync_qd;
   logic             sync_edge;
   logic [POS_W-1:0] pos_free, pos_target;
   int unsigned      slots_log2;

   always_comb begin
      slots_log2 = frame_slot_log2(rate_16k, if_rate_sel, MAX_SLOT_LOG2);
      last_pos   = POS_W'((SLOT_BITS << slots_log2) - 1);
   end

   // frame sync is sampled on the falling edge
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= 1'b0;
         sync_qd <= 1'b0;
      end else begin
         sync_q  <= sync_in;
         sync_qd <= sync_q;
      end
   end

   assign sync_edge  = sync_q & ~sync_qd & ~master_en;
   assign pos_free   = (pos == last_pos) ? '0 : pos + 1'b1;
   // short: seen in last bit -> next is bit 0; long: seen in bit 0 -> next is bit 1
   assign pos_target = (sync_kind_e'(long_sync) == SYNC_LONG) ? POS_W'(1) : '0;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         lock_q   <= 1'b0;
         resync_q <= 1'b0;
      end else if (sync_edge) begin
         pos    <= pos_target;
         lock_q <= 1'b1;
         if (lock_q && (pos_free != pos_target)) resync_q <= 1'b1;
      end else begin
         pos <= pos_free;
      end
   end

endmodule

// File: rtl/pcm_sync_gen.sv
module pcm_sync_gen
   import pcm_tdm_pkg::*;
#(
   parameter int unsigned POS_W     = 8,
   parameter int unsigned LONG_BITS = 3
) (
   input  logic             master_en,
   input  logic             long_sync,
   input  logic [POS_W-1:0] pos,
   input  logic [POS_W-1:0] last_pos,
   output logic             sync_out,
   output logic             sync_oe
);

   logic in_long, in_short;

   assign in_long  = (pos < POS_W'(LONG_BITS));
   assign in_short = (pos == last_pos);
   // pos changes on rising edges, so the pulse is launched on a rising edge
   assign sync_out = master_en &
                     ((sync_kind_e'(long_sync) == SYNC_LONG) ? in_long : in_short);
   assign sync_oe  = master_en;

endmodule

// File: rtl/pcm_slot_map.sv
module pcm_slot_map #(
   parameter int unsigned N_CH   = 3,
   parameter int unsigned BIT_W  = 4,
   parameter int unsigned SLOT_W = 4
) (
   input  logic                   bclk,
   input  logic                   rst_n,
   input  logic                   timing_ok,
   input  logic [N_CH-1:0]        ch_en,
   input  logic [N_CH*SLOT_W-1:0] ch_slot,
   input  logic [BIT_W-1:0]       bit_idx,
   input  logic [SLOT_W-1:0]      slot_idx,
   output logic [N_CH-1:0]        slot_active,
   output logic                   dout_oe
);

   logic fall_odd;
   logic last_bit;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign slot_active[c] = timing_ok & ch_en[c] &
                              (ch_slot[c*SLOT_W +: SLOT_W] == slot_idx);
   end

   // records whether the latest falling edge fell in an odd bit; the last
   // bit of a slot is odd, the bit before it even
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) fall_odd <= 1'b0;
      else        fall_odd <= bit_idx[0];
   end

   assign last_bit = &bit_idx;
   assign dout_oe  = (|slot_active) & ~(last_bit & fall_odd);

endmodule

// File: rtl/pcm_tdm_timing.sv
module pcm_tdm_timing
   import pcm_tdm_pkg::*;
#(
   parameter int unsigned SLOT_BITS     = 16,
   parameter int unsigned MAX_SLOT_LOG2 = 4,
   parameter int unsigned N_CH          = 3,
   parameter int unsigned LONG_BITS     = 3
) (
   input  logic                          bclk,
   input  logic                          rst_n,
   input  logic                          master_en,
   input  logic                          long_sync,
   input  logic                          rate_16k,
   input  logic [RATE_SEL_W-1:0]         if_rate_sel,
   input  logic [N_CH-1:0]               ch_en,
   input  logic [N_CH*MAX_SLOT_LOG2-1:0] ch_slot,
   input  logic                          sync_in,
   output logic                          sync_out,
   output logic                          sync_oe,
   output logic [$clog2(SLOT_BITS)-1:0]  bit_idx,
   output logic [MAX_SLOT_LOG2-1:0]      slot_idx,
   output logic                          slot_first,
   output logic                          slot_last,
   output logic [N_CH-1:0]               slot_active,
   output logic                          dout_oe,
   output logic                          locked,
   output logic                          resync_seen
);

   localparam int unsigned BIT_W = $clog2(SLOT_BITS);
   localparam int unsigned POS_W = BIT_W + MAX_SLOT_LOG2;

   if (SLOT_BITS < 4 || (SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_slot
      $error("SLOT_BITS must be a power of two of at least 4");
   end
   if (LONG_BITS == 0 || LONG_BITS >= SLOT_BITS) begin : g_bad_long
      $error("LONG_BITS must lie between 1 and SLOT_BITS-1");
   end
   if (N_CH == 0 || MAX_SLOT_LOG2 == 0) begin : g_bad_count
      $error("N_CH and MAX_SLOT_LOG2 must be nonzero");
   end

   logic [POS_W-1:0] pos, last_pos;
   logic             lock_q;

   pcm_frame_counter #(
      .SLOT_BITS    (SLOT_BITS),
      .MAX_SLOT_LOG2(MAX_SLOT_LOG2)
   ) u_cnt (
      .bclk       (bclk),
      .rst_n      (rst_n),
      .master_en  (master_en),
      .long_sync  (long_sync),
      .rate_16k   (rate_16k),
      .if_rate_sel(if_rate_sel),
      .sync_in    (sync_in),
      .pos        (pos),
      .last_pos   (last_pos),
      .lock_q     (lock_q),
      .resync_q   (resync_seen)
   );

   pcm_sync_gen #(
      .POS_W    (POS_W),
      .LONG_BITS(LONG_BITS)
   ) u_sync (
      .master_en(master_en),
      .long_sync(long_sync),
      .pos      (pos),
      .last_pos (last_pos),
      .sync_out (sync_out),
      .sync_oe  (sync_oe)
   );

   assign bit_idx    = pos[BIT_W-1:0];
   assign slot_idx   = pos[POS_W-1:BIT_W];
   assign slot_first = (bit_idx == '0);
   assign slot_last  = &bit_idx;
   assign locked     = lock_q & ~master_en;

   pcm_slot_map #(
      .N_CH  (N_CH),
      .BIT_W (BIT_W),
      .SLOT_W(MAX_SLOT_LOG2)
   ) u_map (
      .bclk       (bclk),
      .rst_n      (rst_n),
      .timing_ok  (master_en | lock_q),
      .ch_en      (ch_en),
      .ch_slot    (ch_slot),
      .bit_idx    (bit_idx),
      .slot_idx   (slot_idx),
      .slot_active(slot_active),
      .dout_oe    (dout_oe)
   );

endmodule

// File: rtl/pcm_tdm_timing_chk.sv
module pcm_tdm_timing_chk
   import pcm_tdm_pkg::*;
#(
   parameter int unsigned SLOT_BITS     = 16,
   parameter int unsigned MAX_SLOT_LOG2 = 4,
   parameter int unsigned N_CH          = 3
) (
   input logic                         bclk,
   input logic                         rst_n,
   input logic                         master_en,
   input logic                         long_sync,
   input logic                         rate_16k,
   input logic [RATE_SEL_W-1:0]        if_rate_sel,
   input logic                         sync_out,
   input logic [$clog2(SLOT_BITS)-1:0] bit_idx,
   input logic [MAX_SLOT_LOG2-1:0]     slot_idx,
   input logic [N_CH-1:0]              slot_active,
   input logic                         dout_oe,
   input logic                         locked,
   input logic                         resync_seen
);

   logic [MAX_SLOT_LOG2-1:0] top_slot;
   assign top_slot = MAX_SLOT_LOG2'((1 << frame_slot_log2(rate_16k, if_rate_sel, MAX_SLOT_LOG2)) - 1);

   // R1: frame ends after the last slot the rate pair allows
   a_r1_frame_wrap: assert property (@(posedge bclk) disable iff (!rst_n)
      (master_en && (&bit_idx) && slot_idx == top_slot) |=> (slot_idx == '0));

   // R2: bit position steps by one inside a slot
   a_r2_bit_step: assert property (@(posedge bclk) disable iff (!rst_n)
      (master_en && !(&bit_idx)) |=> (bit_idx == $past(bit_idx) + 1'b1));

   // R3: a short sync is followed by bit 0 of slot 0
   a_r3_short_leads_frame: assert property (@(posedge bclk) disable iff (!rst_n)
      (master_en && !long_sync && sync_out) |=> (bit_idx == '0 && slot_idx == '0));

   // R4: a long sync starts together with bit 0 of slot 0
   a_r4_long_with_frame: assert property (@(posedge bclk) disable iff (!rst_n)
      (master_en && long_sync && $rose(sync_out)) |-> (bit_idx == '0 && slot_idx == '0));

   // R5: distinct slot numbers give at most one owner
   a_r5_one_owner: assert property (@(posedge bclk) disable iff (!rst_n)
      $onehot0(slot_active));

   // R6: the output is driven only inside an owned slot
   a_r6_oe_needs_owner: assert property (@(posedge bclk) disable iff (!rst_n)
      dout_oe |-> (slot_active != '0));

   // R7: by the end of a last bit the driver has let go
   a_r7_release_last_bit: assert property (@(posedge bclk) disable iff (!rst_n)
      (&bit_idx) |-> !dout_oe);

   // R10: an unaligned slave owns nothing
   a_r10_unlocked_quiet: assert property (@(posedge bclk) disable iff (!rst_n)
      (!master_en && !locked) |-> (slot_active == '0 && !dout_oe));

   // R11: resync flag is sticky
   a_r11_sticky: assert property (@(posedge bclk) disable iff (!rst_n)
      resync_seen |=> resync_seen);

   // R12: master never flags a resync
   a_r12_master_no_resync: assert property (@(posedge bclk) disable iff (!rst_n)
      master_en |-> !resync_seen);

endmodule

bind pcm_tdm_timing pcm_tdm_timing_chk #(
   .SLOT_BITS    (SLOT_BITS),
   .MAX_SLOT_LOG2(MAX_SLOT_LOG2),
   .N_CH         (N_CH)
) u_chk (
   .bclk       (bclk),
   .rst_n      (rst_n),
   .master_en  (master_en),
   .long_sync  (long_sync),
   .rate_16k   (rate_16k),
   .if_rate_sel(if_rate_sel),
   .sync_out   (sync_out),
   .bit_idx    (bit_idx),
   .slot_idx   (slot_idx),
   .slot_active(slot_active),
   .dout_oe    (dout_oe),
   .locked     (locked),
   .resync_seen(resync_seen)
);

// File: tb/pcm_tdm_timing_tb.sv
module pcm_tdm_timing_tb;

   localparam int N_CH = 3;
   localparam int SW   = 4;

   logic            bclk = 1'b0;
   logic            rst_n;
   logic            master_en, long_sync, rate_16k;
   logic [2:0]      if_rate_sel;
   logic [N_CH-1:0] ch_en;
   logic [N_CH*SW-1:0] ch_slot;
   logic            sync_in;
   logic            sync_out, sync_oe, slot_first, slot_last, dout_oe, locked, resync_seen;
   logic [3:0]      bit_idx;
   logic [SW-1:0]   slot_idx;
   logic [N_CH-1:0] slot_active;

   always #4 bclk = ~bclk;

   pcm_tdm_timing u_dut (
      .bclk(bclk), .rst_n(rst_n), .master_en(master_en), .long_sync(long_sync),
      .rate_16k(rate_16k), .if_rate_sel(if_rate_sel), .ch_en(ch_en), .ch_slot(ch_slot),
      .sync_in(sync_in), .sync_out(sync_out), .sync_oe(sync_oe), .bit_idx(bit_idx),
      .slot_idx(slot_idx), .slot_first(slot_first), .slot_last(slot_last),
      .slot_active(slot_active), .dout_oe(dout_oe), .locked(locked),
      .resync_seen(resync_seen)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model
   int m_pos, m_lock, m_resync;
   bit s_prev, det_pend;

   function automatic int f_log2();
      int s;
      s = int'(if_rate_sel);
      if (rate_16k) s = (s == 0) ? 0 : s - 1;
      if (s > 4) s = 4;
      return s;
   endfunction

   function automatic int f_last();
      return (16 << f_log2()) - 1;
   endfunction

   function automatic int f_free(int p);
      return (p == f_last()) ? 0 : p + 1;
   endfunction

   function automatic int f_target();
      return long_sync ? 1 : 0;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic check_now(bit late);
      int exp_act;
      bit ok;
      string ptag;
      ok = master_en || (m_lock != 0);
      ptag = master_en ? "R2" : (long_sync ? "R9" : "R8");
      chk(ptag, int'(bit_idx), m_pos % 16);
      chk(ptag, int'(slot_idx), m_pos / 16);
      if (master_en && m_pos == f_last()) chk("R1", int'(slot_idx), (1 << f_log2()) - 1);
      exp_act = 0;
      for (int c = 0; c < N_CH; c++)
         if (ok && ch_en[c] && int'(ch_slot[c*SW +: SW]) == m_pos / 16) exp_act |= (1 << c);
      chk(ok ? "R5" : "R10", int'(slot_active), exp_act);
      if (late && (m_pos % 16) == 15)
         chk("R7", int'(dout_oe), 0);
      else
         chk(ok ? "R6" : "R10", int'(dout_oe), (exp_act != 0) ? 1 : 0);
      if (master_en) begin
         if (long_sync) chk("R4", int'(sync_out), (m_pos < 3) ? 1 : 0);
         else           chk("R3", int'(sync_out), (m_pos == f_last()) ? 1 : 0);
         chk("R3", int'(sync_oe), 1);
         chk("R12", int'(resync_seen), 0);
      end else begin
         chk("R10", int'(sync_oe), 0);
         chk("R10", int'(locked), m_lock);
         chk("R11", int'(resync_seen), m_resync);
      end
   endtask

   // one bit period: entered at rising+6, leaves at rising+6
   task automatic tick();
      int fr;
      bit samp;
      @(posedge bclk);
      fr = f_free(m_pos);
      if (det_pend) begin
         if (m_lock != 0 && fr != f_target()) m_resync = 1;
         m_lock = 1;
         m_pos  = f_target();
      end else begin
         m_pos = fr;
      end
      #2 check_now(0);
      #3;
      samp     = sync_in;
      det_pend = samp && !s_prev && !master_en;
      s_prev   = samp;
      #1 check_now(1);
   endtask

   task automatic pick_slots(bit all_on);
      int ns, s;
      int used;
      ns = 1 << f_log2();
      used = 0;
      for (int c = 0; c < N_CH; c++) begin
         if (c < ns) begin
            do s = int'($urandom % ns); while (used[s]);
            used[s] = 1'b1;
            ch_slot[c*SW +: SW] = SW'(s);
            ch_en[c] = all_on ? 1'b1 : 1'($urandom % 2);
         end else begin
            ch_slot[c*SW +: SW] = SW'(15);
            ch_en[c] = 1'b0;
         end
      end
   endtask

   task automatic do_reset(bit mst, bit lng, bit w16, int sel, bit all_on);
      @(posedge bclk);
      #6;
      rst_n = 1'b0;
      sync_in = 1'b0;
      master_en = mst; long_sync = lng; rate_16k = w16; if_rate_sel = 3'(sel);
      pick_slots(all_on);
      m_pos = 0; m_lock = 0; m_resync = 0; s_prev = 0; det_pend = 0;
      repeat (2) @(posedge bclk);
      #6;
      rst_n = 1'b1;
   endtask

   // drive sync per bit: aligned when locked, optional one misplaced pulse
   task automatic run(int n, bit bad);
      bit armed;
      int left, nxt;
      bit drive;
      armed = bad;
      left = 0;
      for (int i = 0; i < n; i++) begin
         nxt = det_pend ? f_target() : f_free(m_pos);
         drive = 1'b0;
         if (master_en) begin
            drive = 1'($urandom % 2);
         end else begin
            if (m_lock != 0) drive = long_sync ? (nxt < 3) : (nxt == f_last());
            if (armed && nxt == 5) begin
               armed = 1'b0;
               left = long_sync ? 3 : 1;
            end
            if (left > 0) begin
               drive = 1'b1;
               left--;
            end
         end
         sync_in = drive;
         tick();
      end
   endtask

   task automatic slave_case(bit lng, bit w16, int sel);
      int len;
      do_reset(1'b0, lng, w16, sel, 1'b1);
      len = f_last() + 1;
      run(30, 1'b0);          // R10: unlocked, no syncs
      run(len + 10, 1'b1);    // R11: first sync misplaced, locks silently
      chk("R11", int'(resync_seen), 0);
      run(2 * len + 8, 1'b0); // aligned syncs keep the flag low
      chk("R11", int'(resync_seen), 0);
      run(len + 10, 1'b1);    // misplaced sync after lock
      chk("R11", int'(resync_seen), 1);
      run(len + 10, 1'b0);
      chk("R11", int'(resync_seen), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      sync_in = 1'b0;
      master_en = 1'b0; long_sync = 1'b0; rate_16k = 1'b0; if_rate_sel = 3'd2;
      ch_en = '0; ch_slot = '0;

      // R13: reset state (slave, so nothing may be owned)
      do_reset(1'b0, 1'b0, 1'b0, 2, 1'b1);
      rst_n = 1'b0;
      @(posedge bclk);
      #2;
      chk("R13", int'(bit_idx), 0);
      chk("R13", int'(slot_idx), 0);
      chk("R13", int'(locked), 0);
      chk("R13", int'(resync_seen), 0);
      chk("R13", int'(dout_oe), 0);

      // R1: every valid rate pair in master mode, alternating sync kinds
      for (int k = 0; k < 9; k++) begin
         bit w16;
         int sel;
         w16 = (k >= 5);
         sel = w16 ? k - 4 : k;
         do_reset(1'b1, 1'(k % 2), w16, sel, 1'b1);
         run(2 * (f_last() + 1) + 5, 1'b0);
      end

      // constrained random master configurations (sync_in toggles: R12)
      for (int k = 0; k < 10; k++) begin
         bit w16;
         int sel;
         w16 = 1'($urandom % 2);
         sel = w16 ? 1 + int'($urandom % 4) : int'($urandom % 5);
         do_reset(1'b1, 1'($urandom % 2), w16, sel, 1'b0);
         run(f_last() + 40, 1'b0);
      end

      // slave alignment, both sync kinds (R8, R9, R10, R11)
      slave_case(1'b0, 1'b0, 2);
      slave_case(1'b1, 1'b0, 2);
      slave_case(1'b0, 1'b1, 1);
      slave_case(1'b1, 1'b0, 0);
      slave_case(1'b1, 1'b1, 3);

      finish_run();
   end

endmodule